// File: doc/BRIEF.md
# Decode-Stage Instruction Pair Fusion Unit

This unit sits in an instruction decode stage and inspects two back-to-back 32-bit base-integer instruction words. It looks for three dependent two-instruction idioms. The first is a small left shift feeding an add, which is a scaled-index address computation. The second is an add whose result is the base of a zero-offset doubleword load, which is an indexed load. The third is a shift left by 32 followed by a logical shift right by 32 on the same register, which zero-extends the low word. When one of these pairs is found, the unit emits a single combined micro-op and reports that both slots were used. Otherwise the first word passes through on its own and one slot is reported as used.

The match is made only from the opcode, function and immediate fields and the register numbers of the two words. The result is registered, so the micro-op for the words presented in one cycle appears on the outputs after the next rising clock edge. The downstream issue logic uses the consumed count to advance its fetch window by one or two words.

Top module: `fuse_pair_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are all zero: `out_valid` 0, `out_kind` 0, `out_consumed` 0 and every field 0.
- R2: Each output is a function of the slot inputs sampled at the preceding rising edge and holds its value between edges.
- R3: A shift-left-immediate (opcode 0010011, funct3 001, bits 31:26 zero) writing rd=d from rs1=a by k, followed by an add (opcode 0110011, funct3 000, funct7 0) with rd=d, rs1=d and rs2=b, gives `out_kind`=1, rd=d, rs1=a, rs2=b, shamt=k and consumed=2 when k is 1, 2 or 3.
- R4: The shift-then-add pair stays unfused when k is outside 1..3, or when the add's rs2 also equals d.
- R5: An add with rd=d, rs1=a and rs2=b, followed by a doubleword load (opcode 0000011, funct3 011) with rd=d, rs1=d and immediate 0, gives `out_kind`=2, rd=d, rs1=a, rs2=b, shamt=0 and consumed=2.
- R6: The add-then-load pair stays unfused when the load immediate is nonzero.
- R7: A shift-left-immediate by 32 writing d from a, followed by a logical shift-right-immediate (opcode 0010011, funct3 101, bits 31:26 zero) by 32 with rd=d and rs1=d, gives `out_kind`=3, rd=d, rs1=a, rs2=0, shamt=32 and consumed=2.
- R8: No pair fuses unless the second word's rd and its rs1 both equal the first word's rd.
- R9: No pair fuses when the shared destination is x0.
- R10: With slot 0 valid and slot 1 not valid, the output is unfused with consumed=1, whatever slot 1 holds.
- R11: With slot 0 not valid, the output has `out_valid` 0 and every other output 0.
- R12: An unfused output has `out_kind`=0, consumed=1, shamt=0, rd/rs1/rs2 equal to bits 11:7, 19:15 and 24:20 of the first word, and `out_insn` equal to the first word. `out_insn` always carries the first word whenever slot 0 is valid.
- R13: Words whose function fields differ from the encodings in R3, R5 and R7 are not recognised. Examples are an add with funct7 0100000 and a right shift with bit 30 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in0_valid | input | 1 | Slot 0 word present |
| in0_insn | input | 32 | Slot 0 instruction word (older) |
| in1_valid | input | 1 | Slot 1 word present |
| in1_insn | input | 32 | Slot 1 instruction word (younger) |
| out_valid | output | 1 | Micro-op present |
| out_kind | output | 2 | 0 unfused, 1 scaled-index add, 2 indexed load, 3 low-word zero-extend |
| out_rd | output | 5 | Destination register |
| out_rs1 | output | 5 | First source register |
| out_rs2 | output | 5 | Second source register |
| out_shamt | output | 6 | Shift amount of the fused op |
| out_consumed | output | 2 | Slots used: 0, 1 or 2 |
| out_insn | output | 32 | Slot 0 word as presented |

## Verification
The decision is purely combinational and is sampled into a single register stage, so the unit has no state that persists beyond one cycle. A wrong internal decision therefore shows at the ports one edge after the offending pair was presented, as a wrong kind, a wrong register field or a wrong consumed count. Two kinds of error matter most. A false fusion, for example across an x0 destination or a mismatched register, would make the downstream logic skip an instruction. A missed fusion would only cost throughput, but the output would still be visibly wrong in that same cycle.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int ILEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int SHAMT_W = 6;
    localparam int SLOTS   = 2;
    localparam int CONS_W  = $clog2(SLOTS + 1);

    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_OP    = 7'b0110011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;

    localparam logic [2:0] F3_SLL  = 3'b001;
    localparam logic [2:0] F3_SRX  = 3'b101;
    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_LDW  = 3'b011;

    typedef enum logic [1:0] {
        FK_PASS       = 2'd0,
        FK_SCALED_ADD = 2'd1,
        FK_IDX_LOAD   = 2'd2,
        FK_ZEXT_LO    = 2'd3
    } fuse_kind_e;

    typedef struct packed {
        logic                 is_slli;
        logic                 is_srli;
        logic                 is_add;
        logic                 is_ld;
        logic [RIDX_W-1:0]    rd;
        logic [RIDX_W-1:0]    rs1;
        logic [RIDX_W-1:0]    rs2;
        logic [SHAMT_W-1:0]   shamt;
        logic                 imm_zero;
    } slot_dec_t;

    typedef struct packed {
        logic                 valid;
        fuse_kind_e           kind;
        logic [RIDX_W-1:0]    rd;
        logic [RIDX_W-1:0]    rs1;
        logic [RIDX_W-1:0]    rs2;
        logic [SHAMT_W-1:0]   shamt;
        logic [CONS_W-1:0]    consumed;
        logic [ILEN-1:0]      insn;
    } uop_t;

    function automatic logic [6:0] w_opcode(input logic [ILEN-1:0] w);
        return w[6:0];
    endfunction

    function automatic logic [2:0] w_funct3(input logic [ILEN-1:0] w);
        return w[14:12];
    endfunction

    function automatic logic [RIDX_W-1:0] w_rd(input logic [ILEN-1:0] w);
        return w[11:7];
    endfunction

    function automatic logic [RIDX_W-1:0] w_rs1(input logic [ILEN-1:0] w);
        return w[19:15];
    endfunction

    function automatic logic [RIDX_W-1:0] w_rs2(input logic [ILEN-1:0] w);
        return w[24:20];
    endfunction

    function automatic logic [SHAMT_W-1:0] w_shamt(input logic [ILEN-1:0] w);
        return w[25:20];
    endfunction

    function automatic logic [6:0] w_funct7(input logic [ILEN-1:0] w);
        return w[31:25];
    endfunction

    function automatic logic [5:0] w_funct6(input logic [ILEN-1:0] w);
        return w[31:26];
    endfunction

endpackage

// File: rtl/fuse_slot_decode.sv
module fuse_slot_decode
    import fuse_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output slot_dec_t       dec
);

    logic [6:0] opc;
    logic [2:0] f3;

    always_comb begin
        opc = w_opcode(insn);
        f3  = w_funct3(insn);

        dec.is_slli  = (opc == OPC_OPIMM) && (f3 == F3_SLL) && (w_funct6(insn) == 6'd0);
        dec.is_srli  = (opc == OPC_OPIMM) && (f3 == F3_SRX) && (w_funct6(insn) == 6'd0);
        dec.is_add   = (opc == OPC_OP)    && (f3 == F3_ADD) && (w_funct7(insn) == 7'd0);
        dec.is_ld    = (opc == OPC_LOAD)  && (f3 == F3_LDW);
        dec.rd       = w_rd(insn);
        dec.rs1      = w_rs1(insn);
        dec.rs2      = w_rs2(insn);
        dec.shamt    = w_shamt(insn);
        dec.imm_zero = (insn[31:20] == 12'd0);
    end

endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
    import fuse_pkg::*;
#(
    parameter int SCALE_MAX = 3,
    parameter int ZEXT_AMT  = 32
) (
    input  logic            v0,
    input  logic            v1,
    input  slot_dec_t       d0,
    input  slot_dec_t       d1,
    input  logic [ILEN-1:0] insn0,
    output uop_t            nxt
);

    localparam logic [SHAMT_W-1:0] SCALE_LO = SHAMT_W'(1);
    localparam logic [SHAMT_W-1:0] SCALE_HI = SHAMT_W'(SCALE_MAX);
    localparam logic [SHAMT_W-1:0] ZEXT_SH  = SHAMT_W'(ZEXT_AMT);

    logic chain;
    logic hit_scaled;
    logic hit_idx;
    logic hit_zext;
    logic any_hit;

    always_comb begin
        chain = v0 && v1
             && (d1.rd  == d0.rd)
             && (d1.rs1 == d0.rd)
             && (d0.rd  != '0);

        hit_scaled = chain && d0.is_slli && d1.is_add
                  && (d0.shamt >= SCALE_LO) && (d0.shamt <= SCALE_HI)
                  && (d1.rs2 != d0.rd);

        hit_idx    = chain && d0.is_add && d1.is_ld && d1.imm_zero;

        hit_zext   = chain && d0.is_slli && d1.is_srli
                  && (d0.shamt == ZEXT_SH) && (d1.shamt == ZEXT_SH);

        any_hit    = hit_scaled || hit_idx || hit_zext;
    end

    always_comb begin
        nxt = '0;
        if (v0) begin
            nxt.valid    = 1'b1;
            nxt.insn     = insn0;
            nxt.rd       = d0.rd;
            nxt.rs1      = d0.rs1;
            nxt.rs2      = d0.rs2;
            nxt.shamt    = '0;
            nxt.kind     = FK_PASS;
            nxt.consumed = CONS_W'(1);
            if (any_hit) begin
                nxt.consumed = CONS_W'(2);
            end
            if (hit_scaled) begin
                nxt.kind  = FK_SCALED_ADD;
                nxt.rs2   = d1.rs2;
                nxt.shamt = d0.shamt;
            end else if (hit_idx) begin
                nxt.kind  = FK_IDX_LOAD;
            end else if (hit_zext) begin
                nxt.kind  = FK_ZEXT_LO;
                nxt.rs2   = '0;
                nxt.shamt = ZEXT_SH;
            end
        end
    end

    // R9: at most one pattern is taken, and never onto x0
    always_comb begin
        if (v0) begin
            assert_single_pattern_R9: assert ($countones({hit_scaled, hit_idx, hit_zext}) <= 1);
            if (any_hit) assert_no_x0_fusion_R9: assert (d0.rd != '0);
        end
    end

endmodule

// File: rtl/fuse_uop_reg.sv
module fuse_uop_reg
    import fuse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  uop_t d,
    output uop_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R1: a reset edge leaves no micro-op behind
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
    import fuse_pkg::*;
#(
    parameter int SCALE_MAX = 3,
    parameter int ZEXT_AMT  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in0_valid,
    input  logic [ILEN-1:0]    in0_insn,
    input  logic               in1_valid,
    input  logic [ILEN-1:0]    in1_insn,
    output logic               out_valid,
    output logic [1:0]         out_kind,
    output logic [RIDX_W-1:0]  out_rd,
    output logic [RIDX_W-1:0]  out_rs1,
    output logic [RIDX_W-1:0]  out_rs2,
    output logic [SHAMT_W-1:0] out_shamt,
    output logic [CONS_W-1:0]  out_consumed,
    output logic [ILEN-1:0]    out_insn
);

    logic [ILEN-1:0] slot_insn [SLOTS];
    slot_dec_t       slot_dec  [SLOTS];
    uop_t            uop_nxt;
    uop_t            uop_q;

    assign slot_insn[0] = in0_insn;
    assign slot_insn[1] = in1_insn;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        fuse_slot_decode u_dec (
            .insn (slot_insn[s]),
            .dec  (slot_dec[s])
        );
    end

    fuse_pair_match #(
        .SCALE_MAX (SCALE_MAX),
        .ZEXT_AMT  (ZEXT_AMT)
    ) u_match (
        .v0    (in0_valid),
        .v1    (in1_valid),
        .d0    (slot_dec[0]),
        .d1    (slot_dec[1]),
        .insn0 (in0_insn),
        .nxt   (uop_nxt)
    );

    fuse_uop_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (uop_nxt),
        .q   (uop_q)
    );

    assign out_valid    = uop_q.valid;
    assign out_kind     = uop_q.kind;
    assign out_rd       = uop_q.rd;
    assign out_rs1      = uop_q.rs1;
    assign out_rs2      = uop_q.rs2;
    assign out_shamt    = uop_q.shamt;
    assign out_consumed = uop_q.consumed;
    assign out_insn     = uop_q.insn;

    // R2: presence of a micro-op follows slot 0 one edge later
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in0_valid |=> out_valid);

    // R3: a scaled-index add carries a shift of 1..SCALE_MAX and uses two slots
    assert_scaled_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd1) |->
            (out_shamt >= SHAMT_W'(1) && out_shamt <= SHAMT_W'(SCALE_MAX) && out_consumed == CONS_W'(2)));

    // R7: a zero-extend carries the fixed shift and no second source
    assert_zext_shape_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd3) |->
            (out_shamt == SHAMT_W'(ZEXT_AMT) && out_rs2 == '0 && out_consumed == CONS_W'(2)));

    // R9: a fused op never targets x0
    assert_fused_rd_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != 2'd0) |-> (out_rd != '0));

    // R10: a lone slot 0 word is passed through alone
    assert_lone_slot_R10: assert property (@(posedge clk) disable iff (rst)
        (in0_valid && !in1_valid) |=> (out_kind == 2'd0 && out_consumed == CONS_W'(1)));

    // R11: no slot 0 word, nothing consumed
    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !in0_valid |=> (!out_valid && out_consumed == '0));

    // R12: unfused output keeps the first word's own fields
    assert_pass_shape_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == 2'd0) |->
            (out_consumed == CONS_W'(1) && out_shamt == '0 && out_rd == out_insn[11:7]));

endmodule

// File: tb/fuse_pair_detect_bench.sv
`timescale 1ns/1ps
module fuse_pair_detect_bench;

    typedef struct packed {
        logic        v;
        logic [1:0]  k;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [5:0]  sh;
        logic [1:0]  c;
        logic [31:0] insn;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        in0_valid, in1_valid;
    logic [31:0] in0_insn, in1_insn;
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [4:0]  out_rd, out_rs1, out_rs2;
    logic [5:0]  out_shamt;
    logic [1:0]  out_consumed;
    logic [31:0] out_insn;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    fuse_pair_detect u_fuse_pair_detect (
        .clk(clk), .rst(rst),
        .in0_valid(in0_valid), .in0_insn(in0_insn),
        .in1_valid(in1_valid), .in1_insn(in1_insn),
        .out_valid(out_valid), .out_kind(out_kind),
        .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
        .out_shamt(out_shamt), .out_consumed(out_consumed), .out_insn(out_insn)
    );

    // ---------------- encoders ----------------
    function automatic logic [31:0] e_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction
    function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction
    function automatic logic [31:0] slli(input logic [4:0] rd, input logic [4:0] rs1, input logic [5:0] sh);
        return e_i({6'd0, sh}, rs1, 3'b001, rd, 7'b0010011);
    endfunction
    function automatic logic [31:0] srli(input logic [4:0] rd, input logic [4:0] rs1, input logic [5:0] sh);
        return e_i({6'd0, sh}, rs1, 3'b101, rd, 7'b0010011);
    endfunction
    function automatic logic [31:0] srai(input logic [4:0] rd, input logic [4:0] rs1, input logic [5:0] sh);
        return e_i({6'b010000, sh}, rs1, 3'b101, rd, 7'b0010011);
    endfunction
    function automatic logic [31:0] add(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        return e_r(7'd0, rs2, rs1, 3'b000, rd, 7'b0110011);
    endfunction
    function automatic logic [31:0] sub(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        return e_r(7'b0100000, rs2, rs1, 3'b000, rd, 7'b0110011);
    endfunction
    function automatic logic [31:0] ld(input logic [4:0] rd, input logic [4:0] rs1, input logic [11:0] imm);
        return e_i(imm, rs1, 3'b011, rd, 7'b0000011);
    endfunction

    function automatic exp_t mk(input logic [1:0] k, input logic [4:0] rd, input logic [4:0] rs1,
                                input logic [4:0] rs2, input logic [5:0] sh, input logic [31:0] insn);
        exp_t e;
        e.v = 1'b1; e.k = k; e.rd = rd; e.rs1 = rs1; e.rs2 = rs2; e.sh = sh;
        e.c = (k == 2'd0) ? 2'd1 : 2'd2; e.insn = insn;
        return e;
    endfunction

    function automatic exp_t pass_of(input logic [31:0] w);
        return mk(2'd0, w[11:7], w[19:15], w[24:20], 6'd0, w);
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(input logic v0, input logic [31:0] a, input logic v1, input logic [31:0] b);
        logic a_sll, a_add, b_add, b_ld, b_srl, link;
        if (!v0) return '0;
        a_sll = a[6:0] == 7'b0010011 && a[14:12] == 3'b001 && a[31:26] == 6'd0;
        a_add = a[6:0] == 7'b0110011 && a[14:12] == 3'b000 && a[31:25] == 7'd0;
        b_add = b[6:0] == 7'b0110011 && b[14:12] == 3'b000 && b[31:25] == 7'd0;
        b_ld  = b[6:0] == 7'b0000011 && b[14:12] == 3'b011;
        b_srl = b[6:0] == 7'b0010011 && b[14:12] == 3'b101 && b[31:26] == 6'd0;
        link  = v1 && b[11:7] == a[11:7] && b[19:15] == a[11:7] && a[11:7] != 5'd0;
        if (link && a_sll && b_add && a[25:20] >= 6'd1 && a[25:20] <= 6'd3 && b[24:20] != a[11:7])
            return mk(2'd1, a[11:7], a[19:15], b[24:20], a[25:20], a);
        if (link && a_add && b_ld && b[31:20] == 12'd0)
            return mk(2'd2, a[11:7], a[19:15], a[24:20], 6'd0, a);
        if (link && a_sll && b_srl && a[25:20] == 6'd32 && b[25:20] == 6'd32)
            return mk(2'd3, a[11:7], a[19:15], 5'd0, 6'd32, a);
        return pass_of(a);
    endfunction

    function automatic exp_t actual();
        exp_t e;
        e.v = out_valid; e.k = out_kind; e.rd = out_rd; e.rs1 = out_rs1; e.rs2 = out_rs2;
        e.sh = out_shamt; e.c = out_consumed; e.insn = out_insn;
        return e;
    endfunction

    task automatic check(input string req, input exp_t exp);
        exp_t act;
        act = actual();
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual v=%0d k=%0d rd=%0d rs1=%0d rs2=%0d sh=%0d c=%0d insn=%h expected v=%0d k=%0d rd=%0d rs1=%0d rs2=%0d sh=%0d c=%0d insn=%h",
                     req, act.v, act.k, act.rd, act.rs1, act.rs2, act.sh, act.c, act.insn,
                     exp.v, exp.k, exp.rd, exp.rs1, exp.rs2, exp.sh, exp.c, exp.insn);
        end
    endtask

    // drive at the falling edge, sample 1 ns after the capturing rising edge
    task automatic step(input logic v0, input logic [31:0] a, input logic v1, input logic [31:0] b);
        @(negedge clk);
        in0_valid = v0; in0_insn = a; in1_valid = v1; in1_insn = b;
        @(posedge clk);
        #1;
    endtask

    task automatic pair(input string req, input logic v0, input logic [31:0] a,
                        input logic v1, input logic [31:0] b, input exp_t exp);
        step(v0, a, v1, b);
        check(req, exp);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual run still active expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        in0_valid = 1'b1; in0_insn = add(5'd3, 5'd4, 5'd5);
        in1_valid = 1'b1; in1_insn = ld(5'd3, 5'd3, 12'd0);
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst = 1'b0;

        // R3: scaled-index add, all legal shifts
        pair("R3", 1, slli(5'd5, 5'd6, 6'd2), 1, add(5'd5, 5'd5, 5'd7), mk(2'd1, 5'd5, 5'd6, 5'd7, 6'd2, slli(5'd5, 5'd6, 6'd2)));
        pair("R3", 1, slli(5'd9, 5'd1, 6'd1), 1, add(5'd9, 5'd9, 5'd2), mk(2'd1, 5'd9, 5'd1, 5'd2, 6'd1, slli(5'd9, 5'd1, 6'd1)));
        pair("R3", 1, slli(5'd31, 5'd30, 6'd3), 1, add(5'd31, 5'd31, 5'd0), mk(2'd1, 5'd31, 5'd30, 5'd0, 6'd3, slli(5'd31, 5'd30, 6'd3)));

        // R2: a new input does not reach the outputs before the next rising edge
        @(negedge clk);
        in0_valid = 1'b1; in0_insn = add(5'd1, 5'd2, 5'd3); in1_valid = 1'b0;
        #1;
        check("R2", mk(2'd1, 5'd31, 5'd30, 5'd0, 6'd3, slli(5'd31, 5'd30, 6'd3)));
        @(posedge clk); #1;
        check("R2", pass_of(add(5'd1, 5'd2, 5'd3)));

        // R4: out-of-range shifts and self-referencing rs2
        pair("R4", 1, slli(5'd5, 5'd6, 6'd4), 1, add(5'd5, 5'd5, 5'd7), pass_of(slli(5'd5, 5'd6, 6'd4)));
        pair("R4", 1, slli(5'd5, 5'd6, 6'd0), 1, add(5'd5, 5'd5, 5'd7), pass_of(slli(5'd5, 5'd6, 6'd0)));
        pair("R4", 1, slli(5'd5, 5'd6, 6'd2), 1, add(5'd5, 5'd5, 5'd5), pass_of(slli(5'd5, 5'd6, 6'd2)));

        // R5 / R6: indexed load
        pair("R5", 1, add(5'd8, 5'd9, 5'd10), 1, ld(5'd8, 5'd8, 12'd0), mk(2'd2, 5'd8, 5'd9, 5'd10, 6'd0, add(5'd8, 5'd9, 5'd10)));
        pair("R6", 1, add(5'd8, 5'd9, 5'd10), 1, ld(5'd8, 5'd8, 12'd8), pass_of(add(5'd8, 5'd9, 5'd10)));
        pair("R6", 1, add(5'd8, 5'd9, 5'd10), 1, ld(5'd8, 5'd8, 12'hfff), pass_of(add(5'd8, 5'd9, 5'd10)));

        // R7: low-word zero-extend
        pair("R7", 1, slli(5'd11, 5'd12, 6'd32), 1, srli(5'd11, 5'd11, 6'd32), mk(2'd3, 5'd11, 5'd12, 5'd0, 6'd32, slli(5'd11, 5'd12, 6'd32)));
        pair("R7", 1, slli(5'd11, 5'd12, 6'd32), 1, srli(5'd11, 5'd11, 6'd31), pass_of(slli(5'd11, 5'd12, 6'd32)));

        // R8: register chaining
        pair("R8", 1, slli(5'd5, 5'd6, 6'd2), 1, add(5'd4, 5'd5, 5'd7), pass_of(slli(5'd5, 5'd6, 6'd2)));
        pair("R8", 1, slli(5'd5, 5'd6, 6'd2), 1, add(5'd5, 5'd7, 5'd5), pass_of(slli(5'd5, 5'd6, 6'd2)));
        pair("R8", 1, add(5'd8, 5'd9, 5'd10), 1, ld(5'd8, 5'd9, 12'd0), pass_of(add(5'd8, 5'd9, 5'd10)));

        // R9: x0 destination
        pair("R9", 1, slli(5'd0, 5'd6, 6'd2), 1, add(5'd0, 5'd0, 5'd7), pass_of(slli(5'd0, 5'd6, 6'd2)));
        pair("R9", 1, add(5'd0, 5'd9, 5'd10), 1, ld(5'd0, 5'd0, 12'd0), pass_of(add(5'd0, 5'd9, 5'd10)));
        pair("R9", 1, slli(5'd0, 5'd12, 6'd32), 1, srli(5'd0, 5'd0, 6'd32), pass_of(slli(5'd0, 5'd12, 6'd32)));

        // R10: matching second word but slot 1 invalid
        pair("R10", 1, add(5'd8, 5'd9, 5'd10), 0, ld(5'd8, 5'd8, 12'd0), pass_of(add(5'd8, 5'd9, 5'd10)));

        // R11: slot 0 invalid
        pair("R11", 0, slli(5'd5, 5'd6, 6'd2), 1, add(5'd5, 5'd5, 5'd7), '0);

        // R12: unrelated word passes with its raw fields
        pair("R12", 1, 32'hdeadbeef, 1, 32'h00000013, pass_of(32'hdeadbeef));

        // R13: near-miss encodings
        pair("R13", 1, sub(5'd8, 5'd9, 5'd10), 1, ld(5'd8, 5'd8, 12'd0), pass_of(sub(5'd8, 5'd9, 5'd10)));
        pair("R13", 1, slli(5'd11, 5'd12, 6'd32), 1, srai(5'd11, 5'd11, 6'd32), pass_of(slli(5'd11, 5'd12, 6'd32)));
        pair("R13", 1, slli(5'd5, 5'd6, 6'd2), 1, sub(5'd5, 5'd5, 5'd7), pass_of(slli(5'd5, 5'd6, 6'd2)));

        // random mix, checked against the model (R3..R13)
        for (int i = 0; i < 400; i++) begin
            logic [4:0]  d, a, b;
            logic [31:0] w0, w1;
            logic        v0, v1;
            int          p;
            d = 5'($urandom % 32); a = 5'($urandom % 32); b = 5'($urandom % 32);
            p = int'($urandom % 4);
            case (p)
                0: begin
                    w0 = slli(d, a, 6'($urandom % 5));
                    w1 = add(d, d, b);
                end
                1: begin
                    w0 = add(d, a, b);
                    w1 = ld(d, d, ($urandom % 4 == 0) ? 12'($urandom) : 12'd0);
                end
                2: begin
                    w0 = slli(d, a, ($urandom % 3 == 0) ? 6'($urandom) : 6'd32);
                    w1 = srli(d, d, ($urandom % 3 == 0) ? 6'($urandom) : 6'd32);
                end
                default: begin
                    w0 = $urandom;
                    w1 = $urandom;
                end
            endcase
            if ($urandom % 5 == 0) w1[11:7]  = 5'($urandom);
            if ($urandom % 5 == 0) w1[19:15] = 5'($urandom);
            v0 = ($urandom % 16) != 0;
            v1 = ($urandom % 8) != 0;
            pair("R3-model", v0, w0, v1, w1, model(v0, w0, v1, w1));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule